// File: doc/BRIEF.md
# Pin function crossbar

This block sits between a group of general-purpose pins and the on-chip peripherals that need them. Each pin has a 5-bit selector register that picks one peripheral signal. Timer, clock and comparator functions take their direction from a per-pin direction bit. Serial and radio lines take their direction from the peripheral's own output enable. The crossbar also applies open-drain drive to lines whose serial interface runs in I2C mode. Two serial interfaces each have a clock and a slave-enable that can land on the same selector code, and the block decides which one gets the pin.

Software, or a sequencer, loads the selectors and direction bytes through a plain register write port. A write takes effect at the next clock edge. Everything after the registers is combinational, so a pin follows its peripheral's signals in the same cycle. Every peripheral input takes its value from the lowest-numbered pin that feeds it, and reads 0 when no pin does. The block has no streaming data path, so every pin is a plain level signal with no valid/ready handshake.

Top module: `pinmux_xbar`

## Requirements
- R1: After reset every selector is 0 and every direction bit is 0. All pins then show oe=0 and out=0, and every peripheral input reads 0 whatever pin_in carries.
- R2: A selector write (cfg_map_we, pin index cfg_map_pin, pin = port*PORT_W + bit) and a direction write (cfg_dir_we, byte per port, bit b of the byte belongs to pin port*PORT_W+b) both land at the next rising edge. A pin index of NPIN or above is ignored, and so is a port index of NPORT or above.
- R3: Code 0 and codes 26..31 carry no function. With the direction bit at 1 the pin drives low (oe=1, out=0). With it at 0 the pin is released and feeds no peripheral input.
- R4: Codes 3,4,5,6 carry sys_clk_o[0..3] and code 8 carries mon_o when the direction bit is 1. With the direction bit at 0 these codes release the pin and feed nothing.
- R5: Codes 1 and 2 drive cmp_o[0]/cmp_o[1] when the direction bit is 1, and feed tclk_i[0]/tclk_i[1] when it is 0. Code 7 drives adc_clk_o when the direction bit is 1 and feeds dma_trig_i when it is 0.
- R6: Codes 9..16 select timer channel k = code-9. With the direction bit at 1 the pin drives tcmp_o[k]. With it at 0 the pin feeds tcap_i[k].
- R7: Serial codes ignore the direction bit. On interface A, code 17 is line 0 and code 18 is line 1. On interface B, code 20 is line 0 and code 21 is line 1. A line's pin takes oe from the interface's doe bit for that line and drives out = do & doe. When oe is 0 the pin feeds di[line].
- R8: Mode encoding is 0 UART, 1 SPI 3-wire, 2 SPI 4-wire, 3 I2C. In I2C mode, lines 0 and 1 of that interface are open drain: out=0, and oe = doe & ~do.
- R9: Code 19 carries A's clock (line 2, direction from sa_doe[2]) when A is in mode 1 or 2. Otherwise it is B's slave enable: an input only, feeding sb_di[3]. sb_force3w is 1 exactly when some pin holds code 19, A is in mode 1 or 2, and B is in mode 2.
- R10: Code 22 carries B's clock (line 2) when B is in mode 1 or 2. Otherwise it is A's slave enable: an input only, feeding sa_di[3]. sa_force3w is 1 exactly when some pin holds code 22, B is in mode 1 or 2, and A is in mode 2.
- R11: Codes 23..25 carry radio line k = code-23 with oe = rf_doe[k] and out = rf_do[k] & oe, and feed rf_di[k] when oe is 0. The direction bit is ignored.
- R12: When several pins feed the same peripheral input, the lowest-numbered pin supplies the value. An input that no pin feeds reads 0.
- R13: On every pin, out is 0 whenever oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_map_we | input | 1 | Selector write strobe |
| cfg_map_pin | input | PIN_IW | Pin index for the selector write |
| cfg_map_code | input | 5 | Selector code to store |
| cfg_dir_we | input | 1 | Direction byte write strobe |
| cfg_dir_port | input | PORT_IW | Port index for the direction write |
| cfg_dir_val | input | PORT_W | Direction bits, 1 = output |
| pin_in | input | NPIN | Pad input levels |
| pin_out | output | NPIN | Pad output levels |
| pin_oe | output | NPIN | Pad output enables |
| cmp_o | input | 2 | Comparator outputs for codes 1, 2 |
| sys_clk_o | input | 4 | Clock outputs for codes 3..6 |
| adc_clk_o | input | 1 | Converter clock for code 7 |
| mon_o | input | 1 | Supply monitor output for code 8 |
| tcmp_o | input | 8 | Timer compare outputs for codes 9..16 |
| tclk_i | output | 2 | Timer clock inputs from codes 1, 2 |
| dma_trig_i | output | 1 | External DMA trigger from code 7 |
| tcap_i | output | 8 | Timer capture inputs from codes 9..16 |
| sa_mode | input | 2 | Interface A mode |
| sa_do | input | 3 | Interface A line drive values, lines 0..2 |
| sa_doe | input | 3 | Interface A line output enables |
| sa_di | output | 4 | Interface A line inputs, bit 3 = slave enable |
| sa_force3w | output | 1 | Interface A must run SPI as 3-wire |
| sb_mode | input | 2 | Interface B mode |
| sb_do | input | 3 | Interface B line drive values |
| sb_doe | input | 3 | Interface B line output enables |
| sb_di | output | 4 | Interface B line inputs, bit 3 = slave enable |
| sb_force3w | output | 1 | Interface B must run SPI as 3-wire |
| rf_do | input | 3 | Radio line drive values |
| rf_doe | input | 3 | Radio line output enables |
| rf_di | output | 3 | Radio line inputs |

## Verification
The hardest state to reach is the shared-pin conflict. A forced 3-wire flag rises only when one pin holds code 19 or 22, the clock owner is in an SPI mode and the other interface is set to 4-wire. The same selector must then fall back to a slave-enable input once the owner leaves SPI. The stimulus reaches this by placing every code on a pin and stepping through all sixteen mode pairs for each direction bit. Random full-map configurations follow, where duplicate codes are common, so the lowest-pin priority is exercised together with the conflict rules.

// File: rtl/pinmux_pkg.sv
`timescale 1ns/1ps
package pinmux_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    SM_UART = 2'd0,
    SM_SPI3 = 2'd1,
    SM_SPI4 = 2'd2,
    SM_I2C  = 2'd3
  } ser_mode_e;

  // selector codes whose value the routing decodes
  localparam logic [CODE_W-1:0] C_DUAL_HI = 5'd16;
  localparam logic [CODE_W-1:0] C_DMA     = 5'd7;
  localparam logic [CODE_W-1:0] C_TCC_LO  = 5'd9;
  localparam logic [CODE_W-1:0] C_SA_L0   = 5'd17;
  localparam logic [CODE_W-1:0] C_SA_L1   = 5'd18;
  localparam logic [CODE_W-1:0] C_SHARE_A = 5'd19;
  localparam logic [CODE_W-1:0] C_SB_L0   = 5'd20;
  localparam logic [CODE_W-1:0] C_SB_L1   = 5'd21;
  localparam logic [CODE_W-1:0] C_SHARE_B = 5'd22;
  localparam logic [CODE_W-1:0] C_RF_LO   = 5'd23;
  localparam logic [CODE_W-1:0] C_RF_HI   = 5'd25;

  // fixed-function source vector layout
  localparam int SRC_W  = 16;
  localparam int SRC_IW = 4;

  // peripheral input (sink) layout
  localparam int SNK_TCLK = 0;
  localparam int SNK_DMA  = 2;
  localparam int SNK_TCAP = 3;
  localparam int SNK_SA   = 11;
  localparam int SNK_SB   = 15;
  localparam int SNK_RF   = 19;
  localparam int SNK_W    = 22;
  localparam int SNK_IW   = 5;

  function automatic logic mode_is_spi(logic [1:0] m);
    return (m == SM_SPI3) || (m == SM_SPI4);
  endfunction
endpackage

// File: rtl/pinmux_cfg_regs.sv
`timescale 1ns/1ps
module pinmux_cfg_regs
  import pinmux_pkg::*;
#(
  parameter int NPORT  = 3,
  parameter int PORT_W = 8,
  localparam int NPIN    = NPORT * PORT_W,
  localparam int PIN_IW  = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int PORT_IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     map_we,
  input  logic [PIN_IW-1:0]        map_pin,
  input  logic [CODE_W-1:0]        map_code,
  input  logic                     dir_we,
  input  logic [PORT_IW-1:0]       dir_port,
  input  logic [PORT_W-1:0]        dir_val,
  output logic [NPIN*CODE_W-1:0]   map_flat,
  output logic [NPIN-1:0]          dir_flat
);
  logic [CODE_W-1:0] map_q [NPIN];
  logic [PORT_W-1:0] dir_q [NPORT];

  // one selector per pin; a pin index past the last pin matches nothing
  for (genvar p = 0; p < NPIN; p++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[p] <= '0;
      else if (map_we && (map_pin == PIN_IW'(p)))
        map_q[p] <= map_code;
    end
    assign map_flat[p*CODE_W +: CODE_W] = map_q[p];
  end

  for (genvar q = 0; q < NPORT; q++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dir_q[q] <= '0;
      else if (dir_we && (dir_port == PORT_IW'(q)))
        dir_q[q] <= dir_val;
    end
    assign dir_flat[q*PORT_W +: PORT_W] = dir_q[q];
  end
endmodule

// File: rtl/pinmux_pin_route.sv
`timescale 1ns/1ps
module pinmux_pin_route
  import pinmux_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              dir,
  input  logic [SRC_W-1:0]  src,
  input  logic [1:0]        sa_mode,
  input  logic [2:0]        sa_do,
  input  logic [2:0]        sa_doe,
  input  logic [1:0]        sb_mode,
  input  logic [2:0]        sb_do,
  input  logic [2:0]        sb_doe,
  input  logic [2:0]        rf_do,
  input  logic [2:0]        rf_doe,
  output logic              out,
  output logic              oe,
  output logic [SNK_W-1:0]  snk,
  output logic              a_clk_claim,
  output logic              b_clk_claim
);
  logic a_spi, b_spi;
  logic use_b, ste, d, e;
  logic [1:0] line, m, rk;
  logic [SNK_IW-1:0] base;

  assign a_spi = mode_is_spi(sa_mode);
  assign b_spi = mode_is_spi(sb_mode);
  assign a_clk_claim = (code == C_SHARE_A) && a_spi;
  assign b_clk_claim = (code == C_SHARE_B) && b_spi;

  always_comb begin
    out   = 1'b0;
    oe    = 1'b0;
    snk   = '0;
    use_b = 1'b0;
    ste   = 1'b0;
    line  = 2'd0;
    d     = 1'b0;
    e     = 1'b0;
    m     = 2'd0;
    rk    = 2'd0;
    base  = '0;
    if (code >= C_SA_L0 && code <= C_SHARE_B) begin
      // serial lines: the interface owns the direction
      case (code)
        C_SA_L0:   line = 2'd0;
        C_SA_L1:   line = 2'd1;
        C_SHARE_A: if (a_spi) line = 2'd2;
                   else begin use_b = 1'b1; ste = 1'b1; end
        C_SB_L0:   begin use_b = 1'b1; line = 2'd0; end
        C_SB_L1:   begin use_b = 1'b1; line = 2'd1; end
        default:   if (b_spi) begin use_b = 1'b1; line = 2'd2; end
                   else ste = 1'b1;
      endcase
      base = use_b ? SNK_IW'(SNK_SB) : SNK_IW'(SNK_SA);
      if (ste) begin
        snk[base + SNK_IW'(3)] = 1'b1;
      end else begin
        d = use_b ? sb_do[line]  : sa_do[line];
        e = use_b ? sb_doe[line] : sa_doe[line];
        m = use_b ? sb_mode      : sa_mode;
        if (line != 2'd2 && m == SM_I2C) begin
          oe = e & ~d;
        end else begin
          oe  = e;
          out = d & e;
        end
        if (!oe) snk[base + SNK_IW'(line)] = 1'b1;
      end
    end else if (code >= C_RF_LO && code <= C_RF_HI) begin
      rk  = 2'(code - C_RF_LO);
      oe  = rf_doe[rk];
      out = rf_do[rk] & rf_doe[rk];
      if (!oe) snk[SNK_IW'(SNK_RF) + SNK_IW'(rk)] = 1'b1;
    end else if (code != '0 && code <= C_DUAL_HI) begin
      // direction-bit functions, codes 1..16
      if (dir) begin
        oe  = 1'b1;
        out = src[SRC_IW'(code - 5'd1)];
      end else if (code <= 5'd2) begin
        snk[SNK_IW'(code - 5'd1)] = 1'b1;
      end else if (code == C_DMA) begin
        snk[SNK_DMA] = 1'b1;
      end else if (code >= C_TCC_LO) begin
        snk[SNK_IW'(code - 5'd6)] = 1'b1;
      end
    end else begin
      // no function or reserved: drive low when set as output
      oe = dir;
    end
  end
endmodule

// File: rtl/pinmux_sink_sel.sv
`timescale 1ns/1ps
module pinmux_sink_sel
  import pinmux_pkg::*;
#(
  parameter int NPIN = 24
) (
  input  logic [NPIN*SNK_W-1:0] snk_flat,
  input  logic [NPIN-1:0]       pin_in,
  output logic [SNK_W-1:0]      val
);
  for (genvar s = 0; s < SNK_W; s++) begin : g_sink
    logic v;
    // scan from the top so the lowest claiming pin is written last
    always_comb begin
      v = 1'b0;
      for (int p = NPIN - 1; p >= 0; p--) begin
        if (snk_flat[p*SNK_W + s]) v = pin_in[p];
      end
    end
    assign val[s] = v;
  end
endmodule

// File: rtl/pinmux_xbar.sv
`timescale 1ns/1ps
module pinmux_xbar
  import pinmux_pkg::*;
#(
  parameter int NPORT  = 3,
  parameter int PORT_W = 8,
  localparam int NPIN    = NPORT * PORT_W,
  localparam int PIN_IW  = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int PORT_IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_map_we,
  input  logic [PIN_IW-1:0]  cfg_map_pin,
  input  logic [4:0]         cfg_map_code,
  input  logic               cfg_dir_we,
  input  logic [PORT_IW-1:0] cfg_dir_port,
  input  logic [PORT_W-1:0]  cfg_dir_val,
  input  logic [NPIN-1:0]    pin_in,
  output logic [NPIN-1:0]    pin_out,
  output logic [NPIN-1:0]    pin_oe,
  input  logic [1:0]         cmp_o,
  input  logic [3:0]         sys_clk_o,
  input  logic               adc_clk_o,
  input  logic               mon_o,
  input  logic [7:0]         tcmp_o,
  output logic [1:0]         tclk_i,
  output logic               dma_trig_i,
  output logic [7:0]         tcap_i,
  input  logic [1:0]         sa_mode,
  input  logic [2:0]         sa_do,
  input  logic [2:0]         sa_doe,
  output logic [3:0]         sa_di,
  output logic               sa_force3w,
  input  logic [1:0]         sb_mode,
  input  logic [2:0]         sb_do,
  input  logic [2:0]         sb_doe,
  output logic [3:0]         sb_di,
  output logic               sb_force3w,
  input  logic [2:0]         rf_do,
  input  logic [2:0]         rf_doe,
  output logic [2:0]         rf_di
);
  logic [NPIN*CODE_W-1:0] map_flat;
  logic [NPIN-1:0]        dir_flat;
  logic [SRC_W-1:0]       src;
  logic [NPIN*SNK_W-1:0]  snk_flat;
  logic [NPIN-1:0]        a_claim, b_claim;
  logic [SNK_W-1:0]       snk_val;

  pinmux_cfg_regs #(.NPORT(NPORT), .PORT_W(PORT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .map_we   (cfg_map_we),
    .map_pin  (cfg_map_pin),
    .map_code (cfg_map_code),
    .dir_we   (cfg_dir_we),
    .dir_port (cfg_dir_port),
    .dir_val  (cfg_dir_val),
    .map_flat (map_flat),
    .dir_flat (dir_flat)
  );

  assign src = {tcmp_o, mon_o, adc_clk_o, sys_clk_o, cmp_o};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pinmux_pin_route u_route (
      .code        (map_flat[p*CODE_W +: CODE_W]),
      .dir         (dir_flat[p]),
      .src         (src),
      .sa_mode     (sa_mode),
      .sa_do       (sa_do),
      .sa_doe      (sa_doe),
      .sb_mode     (sb_mode),
      .sb_do       (sb_do),
      .sb_doe      (sb_doe),
      .rf_do       (rf_do),
      .rf_doe      (rf_doe),
      .out         (pin_out[p]),
      .oe          (pin_oe[p]),
      .snk         (snk_flat[p*SNK_W +: SNK_W]),
      .a_clk_claim (a_claim[p]),
      .b_clk_claim (b_claim[p])
    );
  end

  pinmux_sink_sel #(.NPIN(NPIN)) u_sel (
    .snk_flat (snk_flat),
    .pin_in   (pin_in),
    .val      (snk_val)
  );

  assign tclk_i     = snk_val[SNK_TCLK +: 2];
  assign dma_trig_i = snk_val[SNK_DMA];
  assign tcap_i     = snk_val[SNK_TCAP +: 8];
  assign sa_di      = snk_val[SNK_SA +: 4];
  assign sb_di      = snk_val[SNK_SB +: 4];
  assign rf_di      = snk_val[SNK_RF +: 3];

  // a clock that wins a shared pin takes the other side's slave enable away
  assign sb_force3w = (|a_claim) && (sb_mode == SM_SPI4);
  assign sa_force3w = (|b_claim) && (sa_mode == SM_SPI4);
endmodule

// File: rtl/pinmux_xbar_chk.sv
`timescale 1ns/1ps
module pinmux_xbar_chk #(
  parameter int NPORT  = 3,
  parameter int PORT_W = 8,
  localparam int NPIN    = NPORT * PORT_W,
  localparam int PIN_IW  = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int CODE_W  = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_map_we,
  input logic [PIN_IW-1:0]      cfg_map_pin,
  input logic [CODE_W-1:0]      cfg_map_code,
  input logic [NPIN*CODE_W-1:0] map_flat,
  input logic [NPIN-1:0]        pin_out,
  input logic [NPIN-1:0]        pin_oe,
  input logic [1:0]             sa_mode,
  input logic [1:0]             sb_mode,
  input logic [2:0]             sa_doe,
  input logic                   sa_force3w,
  input logic                   sb_force3w
);
  a_r1_released_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0))
    else $error("R1 pins not released after reset");

  a_r2_map_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_map_we && int'(cfg_map_pin) < NPIN) |=>
      map_flat[int'($past(cfg_map_pin))*CODE_W +: CODE_W] == $past(cfg_map_code))
    else $error("R2 selector write did not land");

  a_r13_low_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0)
    else $error("R13 out high on released pin");

  a_r9_b_force_needs_modes: assert property (@(posedge clk) disable iff (!rst_n)
    sb_force3w |-> (sb_mode == 2'd2 && (sa_mode == 2'd1 || sa_mode == 2'd2)))
    else $error("R9 B forced without A clock claim");

  a_r10_a_force_needs_modes: assert property (@(posedge clk) disable iff (!rst_n)
    sa_force3w |-> (sa_mode == 2'd2 && (sb_mode == 2'd1 || sb_mode == 2'd2)))
    else $error("R10 A forced without B clock claim");

  for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
    logic [CODE_W-1:0] c;
    assign c = map_flat[p*CODE_W +: CODE_W];

    a_r8_b_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_mode == 2'd3 && (c == 5'd20 || c == 5'd21)) |-> !pin_out[p])
      else $error("R8 B I2C line driven high");

    a_r8_a_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (sa_mode == 2'd3 && (c == 5'd17 || c == 5'd18)) |-> !pin_out[p])
      else $error("R8 A I2C line driven high");

    a_r7_a_line1_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 5'd18 && sa_mode != 2'd3) |-> (pin_oe[p] == sa_doe[1]))
      else $error("R7 serial direction not from interface");
  end
endmodule

bind pinmux_xbar pinmux_xbar_chk #(.NPORT(NPORT), .PORT_W(PORT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_map_we   (cfg_map_we),
  .cfg_map_pin  (cfg_map_pin),
  .cfg_map_code (cfg_map_code),
  .map_flat     (map_flat),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .sa_mode      (sa_mode),
  .sb_mode      (sb_mode),
  .sa_doe       (sa_doe),
  .sa_force3w   (sa_force3w),
  .sb_force3w   (sb_force3w)
);

// File: tb/tb_pinmux_xbar.sv
`timescale 1ns/1ps
module tb_pinmux_xbar;
  localparam int NPORT = 3;
  localparam int PORT_W = 8;
  localparam int NPIN = NPORT * PORT_W;
  localparam int PIN_IW = 5;
  localparam int PORT_IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_map_we = 1'b0;
  logic [PIN_IW-1:0] cfg_map_pin = '0;
  logic [4:0] cfg_map_code = '0;
  logic cfg_dir_we = 1'b0;
  logic [PORT_IW-1:0] cfg_dir_port = '0;
  logic [PORT_W-1:0] cfg_dir_val = '0;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe;
  logic [1:0] cmp_o = '0;
  logic [3:0] sys_clk_o = '0;
  logic adc_clk_o = 1'b0, mon_o = 1'b0;
  logic [7:0] tcmp_o = '0;
  logic [1:0] tclk_i;
  logic dma_trig_i;
  logic [7:0] tcap_i;
  logic [1:0] sa_mode = '0, sb_mode = '0;
  logic [2:0] sa_do = '0, sa_doe = '0, sb_do = '0, sb_doe = '0, rf_do = '0, rf_doe = '0;
  logic [3:0] sa_di, sb_di;
  logic sa_force3w, sb_force3w;
  logic [2:0] rf_di;

  always #2.5 clk = ~clk;

  pinmux_xbar #(.NPORT(NPORT), .PORT_W(PORT_W)) dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_code [NPIN];
  bit m_dir [NPIN];

  logic [NPIN-1:0] e_out, e_oe;
  logic [21:0] e_snk;
  logic e_fa, e_fb;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ser_pin(logic d, logic e, logic od);
    if (od) return {e & ~d, 1'b0};
    return {e, d & e};
  endfunction

  // reference model, written per code from the requirements
  task automatic model();
    logic [21:0] seen;
    bit a_spi, b_spi;
    seen = '0; e_snk = '0; e_out = '0; e_oe = '0; e_fa = 0; e_fb = 0;
    a_spi = (sa_mode == 2'd1 || sa_mode == 2'd2);
    b_spi = (sb_mode == 2'd1 || sb_mode == 2'd2);
    for (int p = 0; p < NPIN; p++) begin
      int c;
      int f;
      bit d;
      logic [1:0] r;
      c = m_code[p]; d = m_dir[p]; f = -1; r = 2'b00;
      case (c)
        1, 2: if (d) r = {1'b1, cmp_o[c-1]}; else f = c - 1;
        3, 4, 5, 6: if (d) r = {1'b1, sys_clk_o[c-3]};
        7: if (d) r = {1'b1, adc_clk_o}; else f = 2;
        8: if (d) r = {1'b1, mon_o};
        9, 10, 11, 12, 13, 14, 15, 16: if (d) r = {1'b1, tcmp_o[c-9]}; else f = 3 + c - 9;
        17: begin r = ser_pin(sa_do[0], sa_doe[0], sa_mode == 2'd3); if (!r[1]) f = 11; end
        18: begin r = ser_pin(sa_do[1], sa_doe[1], sa_mode == 2'd3); if (!r[1]) f = 12; end
        19: if (a_spi) begin
              r = ser_pin(sa_do[2], sa_doe[2], 1'b0);
              if (!r[1]) f = 13;
              if (sb_mode == 2'd2) e_fb = 1;
            end else f = 18;
        20: begin r = ser_pin(sb_do[0], sb_doe[0], sb_mode == 2'd3); if (!r[1]) f = 15; end
        21: begin r = ser_pin(sb_do[1], sb_doe[1], sb_mode == 2'd3); if (!r[1]) f = 16; end
        22: if (b_spi) begin
              r = ser_pin(sb_do[2], sb_doe[2], 1'b0);
              if (!r[1]) f = 17;
              if (sa_mode == 2'd2) e_fa = 1;
            end else f = 14;
        23, 24, 25: begin r = ser_pin(rf_do[c-23], rf_doe[c-23], 1'b0); if (!r[1]) f = 19 + c - 23; end
        default: r = {d, 1'b0};
      endcase
      e_oe[p] = r[1];
      e_out[p] = r[0];
      if (f >= 0 && !seen[f]) begin
        seen[f] = 1'b1;
        e_snk[f] = pin_in[p];
      end
    end
  endtask

  task automatic compare_all(string tag);
    model();
    chk(tag, "pin_out", 32'(pin_out), 32'(e_out));
    chk(tag, "pin_oe", 32'(pin_oe), 32'(e_oe));
    chk(tag, "tclk_i", 32'(tclk_i), 32'(e_snk[1:0]));
    chk(tag, "dma_trig_i", 32'(dma_trig_i), 32'(e_snk[2]));
    chk(tag, "tcap_i", 32'(tcap_i), 32'(e_snk[10:3]));
    chk(tag, "sa_di", 32'(sa_di), 32'(e_snk[14:11]));
    chk(tag, "sb_di", 32'(sb_di), 32'(e_snk[18:15]));
    chk(tag, "rf_di", 32'(rf_di), 32'(e_snk[21:19]));
    chk(tag, "sa_force3w", 32'(sa_force3w), 32'(e_fa));
    chk(tag, "sb_force3w", 32'(sb_force3w), 32'(e_fb));
  endtask

  task automatic wr_map(int p, int c);
    @(negedge clk);
    cfg_map_we = 1'b1; cfg_map_pin = PIN_IW'(p); cfg_map_code = 5'(c);
    @(negedge clk);
    cfg_map_we = 1'b0;
    if (p < NPIN) m_code[p] = c;
  endtask

  task automatic wr_dir(int q, logic [PORT_W-1:0] v);
    @(negedge clk);
    cfg_dir_we = 1'b1; cfg_dir_port = PORT_IW'(q); cfg_dir_val = v;
    @(negedge clk);
    cfg_dir_we = 1'b0;
    if (q < NPORT) for (int b = 0; b < PORT_W; b++) m_dir[q*PORT_W + b] = v[b];
  endtask

  task automatic rand_in();
    pin_in = NPIN'($urandom);
    cmp_o = 2'($urandom); sys_clk_o = 4'($urandom);
    adc_clk_o = 1'($urandom); mon_o = 1'($urandom);
    tcmp_o = 8'($urandom);
    sa_do = 3'($urandom); sa_doe = 3'($urandom);
    sb_do = 3'($urandom); sb_doe = 3'($urandom);
    rf_do = 3'($urandom); rf_doe = 3'($urandom);
  endtask

  function automatic string tag_of(int c);
    if (c == 0 || c >= 26) return "R3";
    if ((c >= 3 && c <= 6) || c == 8) return "R4";
    if (c <= 7) return "R5";
    if (c <= 16) return "R6";
    if (c == 19) return "R9";
    if (c == 22) return "R10";
    if (c >= 23) return "R11";
    return "R7";
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int prev;
    void'($urandom(32'd4242));
    for (int p = 0; p < NPIN; p++) begin m_code[p] = 0; m_dir[p] = 0; end
    rand_in();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything released and quiet after reset
    pin_in = '1;
    #1;
    chk("R1", "pin_oe", 32'(pin_oe), 32'h0);
    chk("R1", "pin_out", 32'(pin_out), 32'h0);
    chk("R1", "tcap_i", 32'(tcap_i), 32'h0);
    compare_all("R1");

    // R2: writes land next edge, out-of-range indices ignored
    wr_map(0, 3);
    wr_dir(0, 8'h01);
    #1;
    chk("R2", "pin0 follows clock", 32'(pin_out[0]), 32'(sys_clk_o[0]));
    compare_all("R2");
    wr_map(30, 9);
    wr_dir(3, 8'hFF);
    #1;
    compare_all("R2");
    wr_map(0, 0);
    wr_dir(0, 8'h00);

    // sweep: each code on one pin, both directions, all mode pairs
    prev = 0;
    for (int c = 0; c < 32; c++) begin
      for (int d = 0; d < 2; d++) begin
        int p;
        logic [PORT_W-1:0] dv;
        p = (c * 7 + d * 5) % NPIN;
        wr_map(prev, 0);
        wr_map(p, c);
        dv = PORT_W'($urandom);
        dv[p % PORT_W] = 1'(d);
        wr_dir(p / PORT_W, dv);
        prev = p;
        for (int am = 0; am < 4; am++) begin
          for (int bm = 0; bm < 4; bm++) begin
            @(negedge clk);
            sa_mode = 2'(am); sb_mode = 2'(bm);
            rand_in();
            #1;
            compare_all(tag_of(c));
          end
        end
      end
    end
    wr_map(prev, 0);
    for (int q = 0; q < NPORT; q++) wr_dir(q, '0);

    // R7: serial line ignores the direction bit
    wr_map(1, 18);
    wr_dir(0, 8'h02);
    @(negedge clk);
    sa_mode = 2'd1; sa_doe = 3'b000; pin_in[1] = 1'b1;
    #1;
    chk("R7", "oe from interface", 32'(pin_oe[1]), 32'h0);
    chk("R7", "line1 fed", 32'(sa_di[1]), 32'h1);
    wr_map(1, 0);
    wr_dir(0, 8'h00);

    // R8: open drain on B lines in I2C mode
    wr_map(4, 20);
    wr_map(6, 21);
    @(negedge clk);
    sb_mode = 2'd3; sb_doe = 3'b011; sb_do = 3'b010; pin_in[6] = 1'b1;
    #1;
    chk("R8", "line0 pulls low oe", 32'(pin_oe[4]), 32'h1);
    chk("R8", "line0 out", 32'(pin_out[4]), 32'h0);
    chk("R8", "line1 released oe", 32'(pin_oe[6]), 32'h0);
    chk("R8", "line1 read back", 32'(sb_di[1]), 32'h1);
    compare_all("R8");
    wr_map(4, 0);
    wr_map(6, 0);

    // R9: A clock claims code 19 and forces B to 3-wire
    wr_map(2, 19);
    @(negedge clk);
    sa_mode = 2'd1; sb_mode = 2'd2; sa_doe = 3'b100; sa_do = 3'b100;
    #1;
    chk("R9", "sb_force3w", 32'(sb_force3w), 32'h1);
    chk("R9", "A clock drives", 32'(pin_out[2]), 32'h1);
    @(negedge clk);
    sa_mode = 2'd0; pin_in[2] = 1'b1;
    #1;
    chk("R9", "sb_force3w off", 32'(sb_force3w), 32'h0);
    chk("R9", "B enable fed", 32'(sb_di[3]), 32'h1);
    chk("R9", "enable is input", 32'(pin_oe[2]), 32'h0);
    wr_map(2, 0);

    // R10: B clock claims code 22 and forces A to 3-wire
    wr_map(9, 22);
    @(negedge clk);
    sb_mode = 2'd2; sa_mode = 2'd2; sb_doe = 3'b000; pin_in[9] = 1'b1;
    #1;
    chk("R10", "sa_force3w", 32'(sa_force3w), 32'h1);
    chk("R10", "B clock input fed", 32'(sb_di[2]), 32'h1);
    @(negedge clk);
    sb_mode = 2'd3;
    #1;
    chk("R10", "sa_force3w off", 32'(sa_force3w), 32'h0);
    chk("R10", "A enable fed", 32'(sa_di[3]), 32'h1);
    wr_map(9, 0);

    // R12: lowest pin wins, default 0
    wr_map(3, 12);
    wr_map(10, 12);
    @(negedge clk);
    pin_in[3] = 1'b0; pin_in[10] = 1'b1;
    #1;
    chk("R12", "low pin wins 0", 32'(tcap_i[3]), 32'h0);
    @(negedge clk);
    pin_in[3] = 1'b1; pin_in[10] = 1'b0;
    #1;
    chk("R12", "low pin wins 1", 32'(tcap_i[3]), 32'h1);
    wr_map(3, 0);
    #1;
    chk("R12", "next pin", 32'(tcap_i[3]), 32'h0);
    wr_map(10, 0);
    @(negedge clk);
    pin_in = '1;
    #1;
    chk("R12", "unfed reads 0", 32'(tcap_i[3]), 32'h0);

    // R11: radio line direction from the radio
    wr_map(17, 24);
    @(negedge clk);
    rf_doe = 3'b010; rf_do = 3'b010;
    #1;
    chk("R11", "radio drives", 32'(pin_out[17]), 32'h1);
    compare_all("R11");
    wr_map(17, 0);

    // random full maps with many duplicates
    for (int it = 0; it < 300; it++) begin
      for (int p = 0; p < NPIN; p++) wr_map(p, int'($urandom_range(0, 31)));
      for (int q = 0; q < NPORT; q++) wr_dir(q, PORT_W'($urandom));
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        sa_mode = 2'($urandom); sb_mode = 2'($urandom);
        rand_in();
        #1;
        compare_all("R12");
        chk("R13", "out low when released", 32'(pin_out & ~pin_oe), 32'h0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule